// File: doc/BRIEF.md
# Lockable General-Purpose Pin Bank

A bank of nine general-purpose pins controlled through a simple 32-bit register port. Each pin has its own direction, data, blink, invert and lock bit. When a pin is an output, its data bit drives the pin, with optional polarity inversion. A shared one-hertz blink can also toggle the pin level. When a pin is an input, the pin level passes through a short synchronizer and the optional inversion, and is then captured into the data register on every clock.

The lock bit protects a pin's setup once firmware has chosen it. Software can set a lock bit but never clear it; only the bus reset clears it. While a pin is locked, its direction, blink and invert bits ignore writes. A locked output also ignores writes to its data bit, while a locked input keeps tracking its pin. The lock register also holds two extra groups of sticky bits, which have no effect on any pin.

The blink phase comes from one prescaler that counts a parameterised clock frequency. Every blinking pin flips on the same clock edge, once per half period. Blinking never alters the stored data bit.

Top module: `gpb_top`

## Requirements
- R1: After reset, every register reads zero and no pin is driven (`pin_oe` = 0, `pin_out` = 0).
- R2: Register map, with bit i belonging to pin i. Direction is at byte offset 0x00, data at 0x04, blink at 0x0C, lock at 0x10 and invert at 0x14. In the lock register, bits 19:16 and 28:24 are extra sticky bits. Every other bit reads 0 and ignores writes, and so do offsets 0x08, 0x18 and all other offsets.
- R3: A pin whose direction bit is 1 is an output: `pin_oe` is 1 and `pin_out` equals data XOR invert. The stored data bit is not inverted.
- R4: A pin whose direction bit is 0 is an input: `pin_oe` and `pin_out` are 0. Its data bit captures pin level XOR invert, SYNC_STAGES+1 clocks after the pin changes. Writes to that data bit are ignored.
- R5: An output pin whose blink bit is 1 shows data XOR invert XOR phase. The shared phase flips every CLK_HZ/(2·BLINK_HZ) clocks. The stored data bit is not changed by blinking.
- R6: A blink bit that is 1 on an input pin has no effect on `pin_out` or `pin_oe`.
- R7: Writing 1 to a lock bit (pins or extra bits) sets it. Writing 0 never clears it; only reset does.
- R8: While a pin's lock bit is 1, writes to its direction, blink and invert bits are ignored.
- R9: While a pin's lock bit is 1 and the pin is an output, writes to its data bit are ignored. A locked input's data bit keeps tracking its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset; the only way to clear the lock bits |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Levels sampled from the pins |
| pin_out | output | NUM_PINS | Levels driven onto the pins |
| pin_oe | output | NUM_PINS | Output enable per pin |

## Verification
A corrupted direction, invert or blink bit shows on `pin_oe` or `pin_out` in the same cycle that it reads back wrong. A bad input capture shows in the data readback SYNC_STAGES+1 clocks after the pin changes. A lock bit that silently clears, or a gate that lets a write through, shows on the very next readback of the protected bit after the write. A wrong prescaler limit shows only as a wrong spacing between edges of a blinking pin, so the bench measures that spacing over a full half period.

// File: rtl/gpb_pkg.sv
`timescale 1ns/1ps
package gpb_pkg;
   localparam int BUS_BITS = 32;

   localparam logic [7:0] OFS_DIR   = 8'h00;
   localparam logic [7:0] OFS_DATA  = 8'h04;
   localparam logic [7:0] OFS_BLINK = 8'h0C;
   localparam logic [7:0] OFS_LOCK  = 8'h10;
   localparam logic [7:0] OFS_INV   = 8'h14;

   // extra sticky lock groups inside the lock register
   localparam int XL_A_LSB = 16;
   localparam int XL_A_W   = 4;
   localparam int XL_B_LSB = 24;
   localparam int XL_B_W   = 5;
   localparam int XL_W     = XL_A_W + XL_B_W;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DIR,
      SEL_DATA,
      SEL_BLINK,
      SEL_LOCK,
      SEL_INV
   } reg_sel_e;

   typedef struct packed {
      logic dir;
      logic data;
      logic blink;
      logic lock;
      logic inv;
   } wr_strobe_t;
endpackage

// File: rtl/gpb_decode.sv
`timescale 1ns/1ps
module gpb_decode
   import gpb_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output reg_sel_e          sel,
   output wr_strobe_t        stb
);
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("gpb_decode: ADDR_W must be at least 5");
   end

   always_comb begin
      sel = SEL_NONE;
      if      (addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
      else if (addr == ADDR_W'(OFS_DATA))  sel = SEL_DATA;
      else if (addr == ADDR_W'(OFS_BLINK)) sel = SEL_BLINK;
      else if (addr == ADDR_W'(OFS_LOCK))  sel = SEL_LOCK;
      else if (addr == ADDR_W'(OFS_INV))   sel = SEL_INV;
   end

   always_comb begin
      stb = '0;
      if (wr) begin
         unique case (sel)
            SEL_DIR:   stb.dir   = 1'b1;
            SEL_DATA:  stb.data  = 1'b1;
            SEL_BLINK: stb.blink = 1'b1;
            SEL_LOCK:  stb.lock  = 1'b1;
            SEL_INV:   stb.inv   = 1'b1;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/gpb_timebase.sv
`timescale 1ns/1ps
module gpb_timebase #(
   parameter int CLK_HZ    = 125_000_000,
   parameter int BLINK_HZ  = 1,
   parameter bit BLINK_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);
   localparam int HALF = CLK_HZ / (2 * BLINK_HZ);
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   if (BLINK_HZ < 1) begin : g_bad_rate
      $error("gpb_timebase: BLINK_HZ must be positive");
   end
   if (HALF < 2) begin : g_bad_half
      $error("gpb_timebase: CLK_HZ too small for the blink rate");
   end

   if (BLINK_EN) begin : g_count
      logic [CW-1:0] cnt;
      logic          wrap;

      assign wrap = (cnt == CW'(HALF - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
         end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
         end else begin
            cnt   <= cnt + 1'b1;
         end
      end

      AST_PHASE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         !wrap |=> $stable(phase)); // R5
      AST_PHASE_FLIPS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         wrap |=> (phase != $past(phase))); // R5
      AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         cnt < CW'(HALF)); // R5
   end else begin : g_off
      assign phase = 1'b0;
   end
endmodule

// File: rtl/gpb_sticky.sv
`timescale 1ns/1ps
module gpb_sticky #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic [W-1:0] set_bits,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("gpb_sticky: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (set_en) q <= q | set_bits;
   end

   AST_XLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(q) & ~q) == '0)); // R7
endmodule

// File: rtl/gpb_pin_slice.sv
`timescale 1ns/1ps
module gpb_pin_slice #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_dir,
   input  logic wr_data,
   input  logic wr_blink,
   input  logic wr_lock,
   input  logic wr_inv,
   input  logic wbit,
   input  logic phase,
   input  logic pin_in,
   output logic dir_q,
   output logic data_q,
   output logic blink_q,
   output logic lock_q,
   output logic inv_q,
   output logic pin_out,
   output logic pin_oe
);
   logic pin_s;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpb_pin_slice: SYNC_STAGES must be 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign pin_s = pin_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '0;
         end else begin
            sr[0] <= pin_in;
            for (int k = 1; k < SYNC_STAGES; k++) sr[k] <= sr[k-1];
         end
      end
      assign pin_s = sr[SYNC_STAGES-1];
   end

   // configuration bits: frozen once locked
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= 1'b0;
         blink_q <= 1'b0;
         inv_q   <= 1'b0;
      end else if (!lock_q) begin
         if (wr_dir)   dir_q   <= wbit;
         if (wr_blink) blink_q <= wbit;
         if (wr_inv)   inv_q   <= wbit;
      end
   end

   // lock: set-only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lock_q <= 1'b0;
      else if (wr_lock && wbit) lock_q <= 1'b1;
   end

   // data: captured from pin for inputs, written by software for unlocked outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 data_q <= 1'b0;
      else if (!dir_q)            data_q <= pin_s ^ inv_q;
      else if (wr_data && !lock_q) data_q <= wbit;
   end

   assign pin_oe  = dir_q;
   assign pin_out = dir_q & (data_q ^ inv_q ^ (blink_q & phase));

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R7
   AST_LOCKED_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable({dir_q, blink_q, inv_q})); // R8
   AST_LOCKED_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && dir_q) |=> $stable(data_q)); // R9
   AST_INPUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_q |=> (data_q == $past(pin_s ^ inv_q))); // R4
   AST_BLINK_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q && blink_q && !wr_data) |=> $stable(data_q)); // R5
endmodule

// File: rtl/gpb_top.sv
`timescale 1ns/1ps
module gpb_top
   import gpb_pkg::*;
#(
   parameter int NUM_PINS    = 9,
   parameter int ADDR_W      = 8,
   parameter int CLK_HZ      = 125_000_000,
   parameter int BLINK_HZ    = 1,
   parameter bit BLINK_EN    = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [BUS_BITS-1:0]  bus_wdata,
   output logic [BUS_BITS-1:0]  bus_rdata,
   input  logic [NUM_PINS-1:0]  pin_in,
   output logic [NUM_PINS-1:0]  pin_out,
   output logic [NUM_PINS-1:0]  pin_oe
);
   if (NUM_PINS < 1 || NUM_PINS > XL_A_LSB) begin : g_bad_pins
      $error("gpb_top: NUM_PINS must be 1..16");
   end

   reg_sel_e   sel;
   wr_strobe_t stb;
   logic       phase;

   logic [NUM_PINS-1:0] dir_v, data_v, blink_v, lock_v, inv_v;
   logic [XL_W-1:0]     xl_q;
   logic                unused_wdata;

   assign unused_wdata = ^bus_wdata;

   gpb_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .wr   (bus_wr),
      .sel  (sel),
      .stb  (stb)
   );

   gpb_timebase #(
      .CLK_HZ   (CLK_HZ),
      .BLINK_HZ (BLINK_HZ),
      .BLINK_EN (BLINK_EN)
   ) u_timebase (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpb_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_dir   (stb.dir),
         .wr_data  (stb.data),
         .wr_blink (stb.blink),
         .wr_lock  (stb.lock),
         .wr_inv   (stb.inv),
         .wbit     (bus_wdata[i]),
         .phase    (phase),
         .pin_in   (pin_in[i]),
         .dir_q    (dir_v[i]),
         .data_q   (data_v[i]),
         .blink_q  (blink_v[i]),
         .lock_q   (lock_v[i]),
         .inv_q    (inv_v[i]),
         .pin_out  (pin_out[i]),
         .pin_oe   (pin_oe[i])
      );
   end

   gpb_sticky #(.W(XL_W)) u_xlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (stb.lock),
      .set_bits ({bus_wdata[XL_B_LSB +: XL_B_W], bus_wdata[XL_A_LSB +: XL_A_W]}),
      .q        (xl_q)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_DIR:   bus_rdata[NUM_PINS-1:0] = dir_v;
         SEL_DATA:  bus_rdata[NUM_PINS-1:0] = data_v;
         SEL_BLINK: bus_rdata[NUM_PINS-1:0] = blink_v;
         SEL_INV:   bus_rdata[NUM_PINS-1:0] = inv_v;
         SEL_LOCK: begin
            bus_rdata[NUM_PINS-1:0]        = lock_v;
            bus_rdata[XL_A_LSB +: XL_A_W]  = xl_q[XL_A_W-1:0];
            bus_rdata[XL_B_LSB +: XL_B_W]  = xl_q[XL_W-1:XL_A_W];
         end
         default:   ;
      endcase
   end

   AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (bus_rdata == '0)); // R2
   AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0)); // R4
endmodule

// File: tb/tb_gpb_top.sv
`timescale 1ns/1ps
module tb_gpb_top;
   localparam int NP     = 9;
   localparam int TB_HZ  = 40;
   localparam int HALF   = TB_HZ / 2;
   localparam int SYNC   = 2;
   localparam int NV     = 10;

   localparam logic [7:0] A_DIR = 8'h00, A_DATA = 8'h04, A_BLINK = 8'h0C,
                          A_LOCK = 8'h10, A_INV = 8'h14;

   // {addr, write data, expected readback} - walked in order
   localparam logic [71:0] VEC [NV] = '{
      {8'h00, 32'hFFFF_FFFF, 32'h0000_01FF},
      {8'h14, 32'hFFFF_FFFF, 32'h0000_01FF},
      {8'h14, 32'h0000_0000, 32'h0000_0000},
      {8'h0C, 32'h0000_00A5, 32'h0000_00A5},
      {8'h0C, 32'h0000_0000, 32'h0000_0000},
      {8'h08, 32'hFFFF_FFFF, 32'h0000_0000},
      {8'h00, 32'h0000_00F0, 32'h0000_00F0},
      {8'h04, 32'h0000_01FF, 32'h0000_00F0},
      {8'h00, 32'h0000_0000, 32'h0000_0000},
      {8'h18, 32'hFFFF_FFFF, 32'h0000_0000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #4 clk = ~clk;

   gpb_top #(
      .NUM_PINS(NP), .ADDR_W(8), .CLK_HZ(TB_HZ), .BLINK_HZ(1),
      .BLINK_EN(1'b1), .SYNC_STAGES(SYNC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (SYNC + 2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int first_wait;
      int gap;
      int side_err;
      logic prev;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(A_DIR, r);   chk("R1 dir",   r, 32'h0);
      rd(A_DATA, r);  chk("R1 data",  r, 32'h0);
      rd(A_BLINK, r); chk("R1 blink", r, 32'h0);
      rd(A_LOCK, r);  chk("R1 lock",  r, 32'h0);
      rd(A_INV, r);   chk("R1 inv",   r, 32'h0);
      chk("R1 pin_oe",  32'(pin_oe),  32'h0);
      chk("R1 pin_out", 32'(pin_out), 32'h0);

      // R2: register map walk
      for (int v = 0; v < NV; v++) begin
         wr(VEC[v][71:64], VEC[v][63:32]);
         settle();
         rd(VEC[v][71:64], r);
         chk($sformatf("R2 vector %0d", v), r, VEC[v][31:0]);
      end

      // R3: output path with and without inversion
      wr(A_DIR, 32'h1FF);
      wr(A_DATA, 32'h0A5);
      chk("R3 pin_oe", 32'(pin_oe), 32'h1FF);
      chk("R3 pin_out plain", 32'(pin_out), 32'h0A5);
      wr(A_INV, 32'h00F);
      chk("R3 pin_out inverted", 32'(pin_out), 32'h0AA);
      rd(A_DATA, r); chk("R3 data not inverted", r, 32'h0A5);
      wr(A_INV, 32'h0);
      wr(A_DIR, 32'h0);

      // R4: input capture through inversion, data writes ignored
      wr(A_INV, 32'h003);
      pin_in = 9'h101;
      settle();
      rd(A_DATA, r); chk("R4 input capture", r, 32'h102);
      chk("R4 pin_oe", 32'(pin_oe), 32'h0);
      chk("R4 pin_out", 32'(pin_out), 32'h0);
      wr(A_DATA, 32'h1FF);
      rd(A_DATA, r); chk("R4 input data write ignored", r, 32'h102);
      pin_in = '0;
      wr(A_INV, 32'h0);
      settle();

      // R5 / R6: blink on output pin 0, blink on input pin 1
      wr(A_DIR, 32'h001);
      wr(A_DATA, 32'h000);
      wr(A_BLINK, 32'h003);
      side_err = 0;
      prev = pin_out[0];
      first_wait = 0;
      while (pin_out[0] == prev && first_wait < 2 * HALF + 4) begin
         @(negedge clk);
         first_wait++;
         if (pin_out[1] !== 1'b0 || pin_oe[1] !== 1'b0) side_err++;
      end
      prev = pin_out[0];
      gap = 0;
      while (pin_out[0] == prev && gap < 2 * HALF + 4) begin
         @(negedge clk);
         gap++;
         if (pin_out[1] !== 1'b0 || pin_oe[1] !== 1'b0) side_err++;
      end
      chk("R5 blink half period", 32'(gap), 32'(HALF));
      chk("R6 blink on input pin", 32'(side_err), 32'h0);
      rd(A_DATA, r); chk("R5 data unchanged by blink", r, 32'h0);

      // R7-R9: lock behaviour
      do_reset();
      wr(A_DIR, 32'h003);
      wr(A_DATA, 32'h001);
      wr(A_LOCK, 32'h0101_0003);
      rd(A_LOCK, r); chk("R7 lock set", r, 32'h0101_0003);
      wr(A_LOCK, 32'h0);
      rd(A_LOCK, r); chk("R7 lock not cleared by write", r, 32'h0101_0003);
      wr(A_DIR, 32'h0);
      rd(A_DIR, r); chk("R8 locked direction", r, 32'h003);
      wr(A_INV, 32'h1FF);
      rd(A_INV, r); chk("R8 locked invert", r, 32'h1FC);
      wr(A_DATA, 32'h1FE);
      settle();
      rd(A_DATA, r); chk("R9 locked output data", r, 32'h1FD);
      chk("R9 locked pin_out", 32'(pin_out), 32'h001);
      wr(A_LOCK, 32'h004);
      pin_in = 9'h004;
      settle();
      rd(A_DATA, r); chk("R9 locked input tracks high", r, 32'h1F9);
      pin_in = '0;
      settle();
      rd(A_DATA, r); chk("R9 locked input tracks low", r, 32'h1FD);
      wr(A_BLINK, 32'h1FF);
      rd(A_BLINK, r); chk("R8 locked blink", r, 32'h1F8);
      wr(A_LOCK, 32'hFFFF_FFFF);
      rd(A_LOCK, r); chk("R2 lock field layout", r, 32'h1F0F_01FF);
      do_reset();
      rd(A_LOCK, r); chk("R7 reset clears lock", r, 32'h0);
      wr(A_DIR, 32'h00C);
      rd(A_DIR, r); chk("R7 writable after reset", r, 32'h00C);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule